// File: doc/BRIEF.md
# Parallel-Port Message Download Controller

This block loads a scrolling-sign message into a byte-wide RAM from a host that talks like a PC driving a printer port. A level input selects between run mode and program mode. In run mode the display scanner owns the memory address, the scan clock is allowed to tick, and the controller sits idle with its handshake lines at rest. In program mode the scan clock is gated off, the port data buffers and the memory write mode are switched on, and the write address starts again from zero.

Each active-low strobe from the host, once it has been brought into the system clock domain, captures the byte on the port, writes it at the current address and then steps the address by one, so the message lands column by column in the order it was sent. After each accepted byte the controller answers the host with a BUSY period that ends with an acknowledge pulse, in the manner of a printer. Both durations are parameters counted in system clock cycles.

Top module: `msgDownloadTop`

## Requirements
- R1: While progMode is 0, scanClkEn is 1, bufEn, memWrMode and memWrEn are 0, busy is 0, ackN is 1, memAddr equals scanAddr, and a strobe from the host writes nothing and raises no busy.
- R2: While progMode is 1, scanClkEn is 0, bufEn and memWrMode are 1, and memAddr shows the internal write address.
- R3: The write address is 0 from the first cycle of program mode, before any byte is accepted.
- R4: strobeN is active low and passes through a two-flop synchronizer; each falling edge accepted in program mode gives exactly one single-cycle memWrEn pulse carrying the byte present on portData at detection, written at the current address, after which the address is one higher. Successive bytes occupy consecutive addresses in arrival order.
- R5: busy rises in the same cycle as the write pulse and stays high for BUSY_LEAD + ACK_LEN cycles; ackN is low for the final ACK_LEN of those cycles, and busy falls in the cycle ackN returns high.
- R6: A strobe falling edge that arrives while busy is high is ignored: no write, no change of address.
- R7: The write address wraps from 2^ADDR_W - 1 to 0; the byte after the top address is written at address 0.
- R8: Leaving program mode during a handshake returns busy to 0 and ackN to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| progMode | input | 1 | 1 = program mode, 0 = run mode (debounced level) |
| strobeN | input | 1 | Host data strobe, active low, asynchronous |
| portData | input | DATA_W | Host data byte |
| scanAddr | input | ADDR_W | Address from the display scanner |
| memAddr | output | ADDR_W | Memory address (scanner or write address) |
| memData | output | DATA_W | Byte to be written |
| memWrEn | output | 1 | Single-cycle memory write strobe |
| memWrMode | output | 1 | Holds the memory in write mode |
| bufEn | output | 1 | Enables the port-to-memory data buffers |
| scanClkEn | output | 1 | Enable for the display scan clock |
| busy | output | 1 | Printer-style BUSY |
| ackN | output | 1 | Printer-style acknowledge, active low |

## Verification
On every cycle the assertions check that the address is clear outside program mode, steps by exactly one after each write and wraps at the top, that the write pulse is one cycle wide and coincides with the start of busy, that ackN is only low inside busy and never longer than ACK_LEN, and that busy only ends together with the end of the acknowledge or on leaving program mode. The scenarios are what show that the right bytes reach the right addresses in arrival order, that the busy and acknowledge lengths match the parameters, that a strobe during busy or in run mode leaves memory untouched, and that the address mux and enables follow the mode.

// File: rtl/dlPkg.sv
package dlPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic capture;  // latch port byte
    logic write;    // write pulse, address steps at the end of it
    logic clear;    // hold write address at zero
  } dlCtrl_t;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_LEAD = 2'd1,
    HS_ACK  = 2'd2
  } hsState_t;
endpackage

// File: rtl/dlSync.sv
module dlSync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/dlCtrl.sv
module dlCtrl
  import dlPkg::*;
#(
  parameter int BUSY_LEAD = 4,
  parameter int ACK_LEN   = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    progMode,
  input  logic    strobeSync,
  output dlCtrl_t ctrl,
  output logic    busy,
  output logic    ackN
);
  localparam int MAX_CNT = (BUSY_LEAD > ACK_LEN) ? BUSY_LEAD : ACK_LEN;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  hsState_t   state;
  logic [CNT_W-1:0] cnt;
  logic strobePrev;
  logic writeQ;
  logic fallDet;
  logic acceptNow;

  assign fallDet   = strobePrev & ~strobeSync;
  assign acceptNow = fallDet & progMode & (state == HS_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b1;
      writeQ     <= 1'b0;
    end else begin
      strobePrev <= strobeSync;
      writeQ     <= acceptNow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !progMode) begin
      state <= HS_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        HS_IDLE: if (acceptNow) begin
          state <= HS_LEAD;
          cnt   <= CNT_W'(BUSY_LEAD - 1);
        end
        HS_LEAD: if (cnt == '0) begin
          state <= HS_ACK;
          cnt   <= CNT_W'(ACK_LEN - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        HS_ACK: if (cnt == '0) begin
          state <= HS_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  assign ctrl.capture = acceptNow;
  assign ctrl.write   = writeQ;
  assign ctrl.clear   = ~progMode;
  assign busy = (state != HS_IDLE);
  assign ackN = (state != HS_ACK);

  // Checker: length of the current acknowledge pulse
  logic [CNT_W:0] ackRun;
  always_ff @(posedge clk) begin
    if (!rstN)      ackRun <= '0;
    else if (!ackN) ackRun <= ackRun + 1'b1;
    else            ackRun <= '0;
  end

  a_r5_ack_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> busy);
  a_r5_busy_ends_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && $past(progMode)) |-> $rose(ackN));
  a_r5_ack_length: assert property (@(posedge clk) disable iff (!rstN)
    ackRun <= (CNT_W+1)'(ACK_LEN));
  a_r4_write_single: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.write |=> !ctrl.write);
  a_r5_busy_starts_with_write: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && progMode) |-> ctrl.write);
  a_r8_idle_after_run: assert property (@(posedge clk) disable iff (!rstN)
    !progMode |=> (!busy && ackN));
endmodule

// File: rtl/dlDatapath.sv
module dlDatapath
  import dlPkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlCtrl_t           ctrl,
  input  logic [DATA_W-1:0] portData,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) wrAddr <= '0;
    else if (ctrl.write)     wrAddr <= wrAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             wrData <= '0;
    else if (ctrl.capture) wrData <= portData;
  end

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (wrAddr == '0));
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.write && !ctrl.clear && wrAddr != TOP_ADDR) |=> (wrAddr == $past(wrAddr) + 1'b1));
  a_r7_addr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.write && !ctrl.clear && wrAddr == TOP_ADDR) |=> (wrAddr == '0));
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.write && !ctrl.clear) |=> $stable(wrAddr));
endmodule

// File: rtl/msgDownloadTop.sv
module msgDownloadTop
  import dlPkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_LEAD   = 4,
  parameter int ACK_LEN     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progMode,
  input  logic              strobeN,
  input  logic [DATA_W-1:0] portData,
  input  logic [ADDR_W-1:0] scanAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memWrEn,
  output logic              memWrMode,
  output logic              bufEn,
  output logic              scanClkEn,
  output logic              busy,
  output logic              ackN
);
  dlCtrl_t ctrl;
  logic strobeSync;
  logic [ADDR_W-1:0] wrAddr;

  dlSync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) strobeSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(strobeN), .syncOut(strobeSync));

  dlCtrl #(.BUSY_LEAD(BUSY_LEAD), .ACK_LEN(ACK_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .progMode(progMode), .strobeSync(strobeSync),
    .ctrl(ctrl), .busy(busy), .ackN(ackN));

  dlDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .portData(portData),
    .wrAddr(wrAddr), .wrData(memData));

  assign memAddr   = progMode ? wrAddr : scanAddr;
  assign memWrEn   = ctrl.write & progMode;
  assign memWrMode = progMode;
  assign bufEn     = progMode;
  assign scanClkEn = ~progMode;
endmodule

// File: tb/msgDownloadTop_tb_top.sv
module msgDownloadTop_tb_top;
  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int LEAD  = 3;
  localparam int ACKL  = 5;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 8;

  // {data, expected address after the byte}
  localparam logic [DW+AW-1:0] VEC [NVEC] = '{
    {8'hA5, 5'd1}, {8'h3C, 5'd2}, {8'h00, 5'd3}, {8'hFF, 5'd4},
    {8'h7F, 5'd5}, {8'h80, 5'd6}, {8'h12, 5'd7}, {8'hE1, 5'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progMode = 1'b0;
  logic strobeN = 1'b1;
  logic [DW-1:0] portData = '0;
  logic [AW-1:0] scanAddr = 5'd17;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic memWrEn, memWrMode, bufEn, scanClkEn, busy, ackN;

  int checks = 0;
  int fails = 0;
  int writeTot = 0;
  int busyTot = 0;
  int ackTot = 0;
  logic [DW-1:0] mem [DEPTH];

  always #2.5 clk = ~clk;

  msgDownloadTop #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2),
                   .BUSY_LEAD(LEAD), .ACK_LEN(ACKL)) dut_i (
    .clk(clk), .rstN(rstN), .progMode(progMode), .strobeN(strobeN),
    .portData(portData), .scanAddr(scanAddr), .memAddr(memAddr),
    .memData(memData), .memWrEn(memWrEn), .memWrMode(memWrMode),
    .bufEn(bufEn), .scanClkEn(scanClkEn), .busy(busy), .ackN(ackN));

  // Memory model and activity counters
  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr] <= memData;
      writeTot <= writeTot + 1;
    end
    if (busy)  busyTot <= busyTot + 1;
    if (!ackN) ackTot  <= ackTot + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [DW-1:0] d);
    @(negedge clk);
    portData = d;
    strobeN  = 1'b0;
    repeat (4) @(negedge clk);
    strobeN = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w0, b0, a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: run mode levels after reset
    check(memAddr == scanAddr, "R1 memAddr follows scanAddr", memAddr, scanAddr);
    check(scanClkEn && !bufEn && !memWrMode && !memWrEn, "R1 run enables",
          {scanClkEn, bufEn, memWrMode, memWrEn}, 4'b1000);
    check(!busy && ackN, "R1 handshake idle", {busy, ackN}, 2'b01);

    // R1: strobe in run mode ignored
    w0 = writeTot; b0 = busyTot;
    sendByte(8'h5A);
    check(writeTot == w0, "R1 no write in run mode", writeTot - w0, 0);
    check(busyTot == b0, "R1 no busy in run mode", busyTot - b0, 0);

    // R2, R3: enter program mode
    @(negedge clk);
    progMode = 1'b1;
    @(negedge clk);
    check(memAddr == 0, "R3 address zero on entry", memAddr, 0);
    check(!scanClkEn && bufEn && memWrMode, "R2 program enables",
          {scanClkEn, bufEn, memWrMode}, 3'b011);

    // R4, R5: table of bytes
    for (int i = 0; i < NVEC; i++) begin
      w0 = writeTot; b0 = busyTot; a0 = ackTot;
      sendByte(VEC[i][DW+AW-1:AW]);
      check(mem[i] == VEC[i][DW+AW-1:AW], "R4 stored byte", mem[i], VEC[i][DW+AW-1:AW]);
      check(memAddr == VEC[i][AW-1:0], "R4 address after byte", memAddr, VEC[i][AW-1:0]);
      check(writeTot - w0 == 1, "R4 one write per strobe", writeTot - w0, 1);
      check(busyTot - b0 == LEAD + ACKL, "R5 busy length", busyTot - b0, LEAD + ACKL);
      check(ackTot - a0 == ACKL, "R5 ack length", ackTot - a0, ACKL);
    end

    // R6: second strobe during busy is ignored
    w0 = writeTot;
    @(negedge clk);
    portData = 8'h66;
    strobeN  = 1'b0;
    repeat (4) @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
    check(busy, "R6 busy during second strobe", busy, 1);
    portData = 8'h99;
    strobeN  = 1'b0;
    repeat (3) @(negedge clk);
    strobeN = 1'b1;
    repeat (20) @(negedge clk);
    check(writeTot - w0 == 1, "R6 strobe in busy ignored", writeTot - w0, 1);
    check(memAddr == 9, "R6 address advanced once", memAddr, 9);
    check(mem[8] == 8'h66, "R6 first byte kept", mem[8], 8'h66);

    // R7: fill to the top and wrap
    for (int a = 9; a < DEPTH; a++) sendByte(8'(a + 8'h40));
    check(memAddr == 0, "R7 address wrapped", memAddr, 0);
    check(mem[DEPTH-1] == 8'(DEPTH - 1 + 8'h40), "R7 top byte", mem[DEPTH-1], DEPTH - 1 + 8'h40);
    sendByte(8'hC3);
    check(mem[0] == 8'hC3, "R7 byte after top at zero", mem[0], 8'hC3);
    check(memAddr == 1, "R7 address after wrap write", memAddr, 1);

    // R8: abort handshake by leaving program mode
    @(negedge clk);
    portData = 8'h11;
    strobeN  = 1'b0;
    repeat (6) @(negedge clk);
    check(busy, "R8 busy before abort", busy, 1);
    progMode = 1'b0;
    strobeN  = 1'b1;
    @(negedge clk);
    check(!busy && ackN, "R8 idle after leaving program", {busy, ackN}, 2'b01);
    check(memAddr == scanAddr && scanClkEn, "R1 run mux after abort", memAddr, scanAddr);

    // R3: re-entry clears address
    repeat (2) @(negedge clk);
    progMode = 1'b1;
    @(negedge clk);
    check(memAddr == 0, "R3 address zero on re-entry", memAddr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule